// File: doc/BRIEF.md
# Coprocessor Memory Request Router

This block sits between the native memory interface of a small embedded controller and the memories and buses around it. Each request (address, write data, 4-bit write strobe and a flag that marks an instruction fetch) is captured once. It is then steered to exactly one of four targets: a local program/data RAM, a local register block, or one of two Wishbone master ports. The RAM and the register block see a single-cycle enable with a word index relative to their window, and return read data one cycle later. A non-local request becomes a single Wishbone transaction. The split between the two master ports is made by comparing the address with a cut-off value.

Only one request is in flight at a time. The requester holds `req_valid` until it sees a one-cycle `req_ready`, which carries the read data. A Wishbone error response still completes the access, returns zero as read data, and sets a flag that stays set until reset. Instruction fetches use the same routing as data accesses. On the bus they are marked by a per-port fetch tag.

Top module: `cpmem_router`

## Requirements
- R1: After reset `req_ready`, `ram_en`, `reg_en`, `m0_cyc`, `m1_cyc` and `bus_fault` are all 0.
- R2: A request with address in [0x10002000, 0x10003000) raises `ram_en` for exactly one cycle, the cycle after capture. It gives `ram_addr` = (address − 0x10002000) / 4. `req_ready` follows in the next cycle with `req_rdata` = `ram_rdata`.
- R3: A request with address in [0x10003000, 0x10003080) behaves like R2 on the register port. It uses `reg_addr` = (address − 0x10003000) / 4 and `reg_rdata`.
- R4: Any other address goes to master port 0 when below 0x50000000 and to master port 1 otherwise. Across `ram_en`, `reg_en`, `m0_cyc` and `m1_cyc`, never more than one is high, and only the decoded target is used.
- R5: On a master port, `cyc` and `stb` stay high from the cycle after capture until the cycle in which `ack` or `err` is seen. While `stall` is high, address, select and write data do not change. A request produces exactly one such transaction.
- R6: `req_ready` is a single-cycle pulse, one cycle after the acknowledging cycle. `req_rdata` carries that cycle's `dat_r`, and is 0 whenever `req_ready` is low.
- R7: A Wishbone `err` ends the access like `ack`, but with `req_rdata` = 0. It sets `bus_fault`, which stays 1 until reset.
- R8: Writes (`req_wstrb` ≠ 0) drive `we` = 1 and `sel` = `req_wstrb` on the bus, and `ram_we`/`reg_we` = `req_wstrb` locally. Reads drive `we` = 0, `sel` = 4'hF and local write enables of 0.
- R9: `req_fetch` does not change routing. On the chosen master port the fetch tag output equals `req_fetch` for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester holds a request |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte write strobe, 0 for reads |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid with req_ready |
| bus_fault | output | 1 | Sticky Wishbone error flag |
| ram_en | output | 1 | Local RAM access strobe |
| ram_we | output | 4 | Local RAM byte write enables |
| ram_addr | output | 10 | Local RAM word index |
| ram_wdata | output | 32 | Local RAM write data |
| ram_rdata | input | 32 | Local RAM read data, one cycle after ram_en |
| reg_en | output | 1 | Register block access strobe |
| reg_we | output | 4 | Register block byte write enables |
| reg_addr | output | 5 | Register word index |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, one cycle after reg_en |
| m0_cyc | output | 1 | Port 0 bus cycle |
| m0_stb | output | 1 | Port 0 strobe |
| m0_we | output | 1 | Port 0 write |
| m0_adr | output | 32 | Port 0 byte address |
| m0_sel | output | 4 | Port 0 byte selects |
| m0_dat_w | output | 32 | Port 0 write data |
| m0_fetch | output | 1 | Port 0 fetch tag |
| m0_dat_r | input | 32 | Port 0 read data |
| m0_ack | input | 1 | Port 0 acknowledge |
| m0_err | input | 1 | Port 0 error |
| m0_stall | input | 1 | Port 0 stall |
| m1_cyc | output | 1 | Port 1 bus cycle |
| m1_stb | output | 1 | Port 1 strobe |
| m1_we | output | 1 | Port 1 write |
| m1_adr | output | 32 | Port 1 byte address |
| m1_sel | output | 4 | Port 1 byte selects |
| m1_dat_w | output | 32 | Port 1 write data |
| m1_fetch | output | 1 | Port 1 fetch tag |
| m1_dat_r | input | 32 | Port 1 read data |
| m1_ack | input | 1 | Port 1 acknowledge |
| m1_err | input | 1 | Port 1 error |
| m1_stall | input | 1 | Port 1 stall |

## Verification
The bench goes after the window edges: the last word below each window, the first and last word inside it, the first word past it, and the words on either side of the port cut-off. An off-by-one compare there sends a request to the wrong target, which shows up as a wrong enable or an unexpected bus cycle. Accesses are also swept across every value of the top address nibble, with several stall and wait lengths. A design that re-issued or dropped the strobe under stall would change the cycle count or the held address. The error response is checked for zero data and for a flag that survives later good accesses and clears only on reset. A design that forwarded the slave's error-cycle data, or let the flag fall, would be caught.

// File: rtl/cpmr_pkg.sv
package cpmr_pkg;

   typedef enum logic [1:0] {
      TGT_RAM  = 2'd0,
      TGT_REG  = 2'd1,
      TGT_BUS0 = 2'd2,
      TGT_BUS1 = 2'd3
   } cpmr_tgt_e;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_LOCAL     = 3'd1,
      ST_LOCAL_RSP = 3'd2,
      ST_BUS       = 3'd3,
      ST_BUS_RSP   = 3'd4
   } cpmr_state_e;

   localparam int unsigned NUM_BUS_PORTS = 2;

endpackage

// File: rtl/cpmr_decode.sv
module cpmr_decode
   import cpmr_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 32,
   parameter logic [ADDR_W-1:0]    RAM_BASE   = 32'h1000_2000,
   parameter int unsigned          RAM_BYTES  = 32'h0000_1000,
   parameter logic [ADDR_W-1:0]    REG_BASE   = 32'h1000_3000,
   parameter int unsigned          REG_BYTES  = 32'h0000_0080,
   parameter logic [ADDR_W-1:0]    SPLIT_ADDR = 32'h5000_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output cpmr_tgt_e         tgt
);

   localparam int unsigned     EXT_W  = ADDR_W + 1;
   localparam logic [EXT_W-1:0] RAM_LO = {1'b0, RAM_BASE};
   localparam logic [EXT_W-1:0] RAM_HI = RAM_LO + EXT_W'(RAM_BYTES);
   localparam logic [EXT_W-1:0] REG_LO = {1'b0, REG_BASE};
   localparam logic [EXT_W-1:0] REG_HI = REG_LO + EXT_W'(REG_BYTES);

   logic [EXT_W-1:0] a_ext;
   assign a_ext = {1'b0, addr};

   // Local windows take precedence over the port split.
   always_comb begin
      if (a_ext >= RAM_LO && a_ext < RAM_HI)
         tgt = TGT_RAM;
      else if (a_ext >= REG_LO && a_ext < REG_HI)
         tgt = TGT_REG;
      else if (addr < SPLIT_ADDR)
         tgt = TGT_BUS0;
      else
         tgt = TGT_BUS1;
   end

endmodule

// File: rtl/cpmr_wb_port.sv
module cpmr_wb_port #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  active,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [DATA_W/8-1:0]   wstrb,
   input  logic                  fetch,
   output logic                  wb_cyc,
   output logic                  wb_stb,
   output logic                  wb_we,
   output logic [ADDR_W-1:0]     wb_adr,
   output logic [DATA_W/8-1:0]   wb_sel,
   output logic [DATA_W-1:0]     wb_dat_w,
   output logic                  wb_fetch,
   input  logic [DATA_W-1:0]     wb_dat_r,
   input  logic                  wb_ack,
   input  logic                  wb_err,
   input  logic                  wb_stall,
   output logic                  done,
   output logic                  fault,
   output logic [DATA_W-1:0]     rdata
);

   localparam int unsigned SEL_W = DATA_W / 8;

   logic accepted_q;
   logic is_write;
   logic resp;

   // Remembers that the slave has taken the strobe, so a late ack
   // arriving together with a stall is still honoured.
   always_ff @(posedge clk) begin
      if (!rst_n)
         accepted_q <= 1'b0;
      else if (!active)
         accepted_q <= 1'b0;
      else if (!wb_stall)
         accepted_q <= 1'b1;
   end

   assign is_write = |wstrb;

   assign wb_cyc   = active;
   assign wb_stb   = active;
   assign wb_we    = active && is_write;
   assign wb_adr   = active ? addr : '0;
   assign wb_sel   = !active ? '0 : (is_write ? wstrb : {SEL_W{1'b1}});
   assign wb_dat_w = wdata;
   assign wb_fetch = active && fetch;

   assign resp  = active && (accepted_q || !wb_stall) && (wb_ack || wb_err);
   assign done  = resp;
   assign fault = resp && wb_err;
   assign rdata = wb_dat_r;

   // R5: strobe and request fields held until the slave answers
   p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cyc && !wb_ack && !wb_err) |=>
         (wb_cyc && wb_stb && $stable(wb_adr) && $stable(wb_sel) && $stable(wb_dat_w)));

   // R8: a read cycle selects every byte lane
   p_read_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cyc && !wb_we) |-> (wb_sel == {SEL_W{1'b1}}));

endmodule

// File: rtl/cpmem_router.sv
module cpmem_router
   import cpmr_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 32,
   parameter int unsigned          DATA_W     = 32,
   parameter logic [ADDR_W-1:0]    RAM_BASE   = 32'h1000_2000,
   parameter int unsigned          RAM_BYTES  = 32'h0000_1000,
   parameter logic [ADDR_W-1:0]    REG_BASE   = 32'h1000_3000,
   parameter int unsigned          REG_BYTES  = 32'h0000_0080,
   parameter logic [ADDR_W-1:0]    SPLIT_ADDR = 32'h5000_0000,
   localparam int unsigned         SEL_W      = DATA_W / 8,
   localparam int unsigned         BYTE_SH    = $clog2(SEL_W),
   localparam int unsigned         RAM_AW     = $clog2(RAM_BYTES / SEL_W),
   localparam int unsigned         REG_AW     = $clog2(REG_BYTES / SEL_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_fetch,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [SEL_W-1:0]     req_wstrb,
   output logic                 req_ready,
   output logic [DATA_W-1:0]    req_rdata,
   output logic                 bus_fault,
   output logic                 ram_en,
   output logic [SEL_W-1:0]     ram_we,
   output logic [RAM_AW-1:0]    ram_addr,
   output logic [DATA_W-1:0]    ram_wdata,
   input  logic [DATA_W-1:0]    ram_rdata,
   output logic                 reg_en,
   output logic [SEL_W-1:0]     reg_we,
   output logic [REG_AW-1:0]    reg_addr,
   output logic [DATA_W-1:0]    reg_wdata,
   input  logic [DATA_W-1:0]    reg_rdata,
   output logic                 m0_cyc,
   output logic                 m0_stb,
   output logic                 m0_we,
   output logic [ADDR_W-1:0]    m0_adr,
   output logic [SEL_W-1:0]     m0_sel,
   output logic [DATA_W-1:0]    m0_dat_w,
   output logic                 m0_fetch,
   input  logic [DATA_W-1:0]    m0_dat_r,
   input  logic                 m0_ack,
   input  logic                 m0_err,
   input  logic                 m0_stall,
   output logic                 m1_cyc,
   output logic                 m1_stb,
   output logic                 m1_we,
   output logic [ADDR_W-1:0]    m1_adr,
   output logic [SEL_W-1:0]     m1_sel,
   output logic [DATA_W-1:0]    m1_dat_w,
   output logic                 m1_fetch,
   input  logic [DATA_W-1:0]    m1_dat_r,
   input  logic                 m1_ack,
   input  logic                 m1_err,
   input  logic                 m1_stall
);

   localparam int unsigned NP = NUM_BUS_PORTS;

   // Elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 16)
      $error("cpmem_router: DATA_W must be a multiple of 8 and at least 16");
   if (RAM_BYTES % SEL_W != 0 || (RAM_BYTES & (RAM_BYTES - 1)) != 0 || RAM_BYTES < 2 * SEL_W)
      $error("cpmem_router: RAM_BYTES must be a power of two of at least two words");
   if (REG_BYTES % SEL_W != 0 || (REG_BYTES & (REG_BYTES - 1)) != 0 || REG_BYTES < 2 * SEL_W)
      $error("cpmem_router: REG_BYTES must be a power of two of at least two words");

   cpmr_state_e            st_q;
   cpmr_tgt_e              tgt_q;
   cpmr_tgt_e              dec_tgt;
   logic [ADDR_W-1:0]      addr_q;
   logic [DATA_W-1:0]      wdata_q;
   logic [SEL_W-1:0]       wstrb_q;
   logic                   fetch_q;
   logic [DATA_W-1:0]      bus_rdata_q;
   logic                   fault_q;

   cpmr_decode #(
      .ADDR_W     (ADDR_W),
      .RAM_BASE   (RAM_BASE),
      .RAM_BYTES  (RAM_BYTES),
      .REG_BASE   (REG_BASE),
      .REG_BYTES  (REG_BYTES),
      .SPLIT_ADDR (SPLIT_ADDR)
   ) u_decode (
      .addr (req_addr),
      .tgt  (dec_tgt)
   );

   // ---------------- bus master ports ----------------
   logic [NP-1:0]              act_a, done_a, fault_a;
   logic [NP-1:0]              cyc_a, stb_a, we_a, ftag_a;
   logic [NP-1:0]              ack_a, err_a, stall_a;
   logic [NP-1:0][ADDR_W-1:0]  adr_a;
   logic [NP-1:0][SEL_W-1:0]   sel_a;
   logic [NP-1:0][DATA_W-1:0]  datw_a, datr_a, rdata_a;

   for (genvar g = 0; g < NP; g++) begin : g_port
      localparam cpmr_tgt_e MY_TGT = (g == 0) ? TGT_BUS0 : TGT_BUS1;
      assign act_a[g] = (st_q == ST_BUS) && (tgt_q == MY_TGT);

      cpmr_wb_port #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W)
      ) u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (act_a[g]),
         .addr     (addr_q),
         .wdata    (wdata_q),
         .wstrb    (wstrb_q),
         .fetch    (fetch_q),
         .wb_cyc   (cyc_a[g]),
         .wb_stb   (stb_a[g]),
         .wb_we    (we_a[g]),
         .wb_adr   (adr_a[g]),
         .wb_sel   (sel_a[g]),
         .wb_dat_w (datw_a[g]),
         .wb_fetch (ftag_a[g]),
         .wb_dat_r (datr_a[g]),
         .wb_ack   (ack_a[g]),
         .wb_err   (err_a[g]),
         .wb_stall (stall_a[g]),
         .done     (done_a[g]),
         .fault    (fault_a[g]),
         .rdata    (rdata_a[g])
      );
   end

   assign m0_cyc = cyc_a[0];  assign m1_cyc = cyc_a[1];
   assign m0_stb = stb_a[0];  assign m1_stb = stb_a[1];
   assign m0_we  = we_a[0];   assign m1_we  = we_a[1];
   assign m0_adr = adr_a[0];  assign m1_adr = adr_a[1];
   assign m0_sel = sel_a[0];  assign m1_sel = sel_a[1];
   assign m0_dat_w = datw_a[0]; assign m1_dat_w = datw_a[1];
   assign m0_fetch = ftag_a[0]; assign m1_fetch = ftag_a[1];
   assign datr_a[0]  = m0_dat_r; assign datr_a[1]  = m1_dat_r;
   assign ack_a[0]   = m0_ack;   assign ack_a[1]   = m1_ack;
   assign err_a[0]   = m0_err;   assign err_a[1]   = m1_err;
   assign stall_a[0] = m0_stall; assign stall_a[1] = m1_stall;

   logic              bus_done;
   logic              bus_err_now;
   logic [DATA_W-1:0] bus_rdata;
   assign bus_done    = |done_a;
   assign bus_err_now = |fault_a;
   assign bus_rdata   = (tgt_q == TGT_BUS1) ? rdata_a[1] : rdata_a[0];

   // ---------------- request sequencing ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         tgt_q       <= TGT_RAM;
         addr_q      <= '0;
         wdata_q     <= '0;
         wstrb_q     <= '0;
         fetch_q     <= 1'b0;
         bus_rdata_q <= '0;
         fault_q     <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  wstrb_q <= req_wstrb;
                  fetch_q <= req_fetch;
                  tgt_q   <= dec_tgt;
                  st_q    <= (dec_tgt == TGT_RAM || dec_tgt == TGT_REG) ? ST_LOCAL : ST_BUS;
               end
            end
            ST_LOCAL:     st_q <= ST_LOCAL_RSP;
            ST_LOCAL_RSP: st_q <= ST_IDLE;
            ST_BUS: begin
               if (bus_done) begin
                  bus_rdata_q <= bus_err_now ? '0 : bus_rdata;
                  if (bus_err_now)
                     fault_q <= 1'b1;
                  st_q <= ST_BUS_RSP;
               end
            end
            ST_BUS_RSP:   st_q <= ST_IDLE;
            default:      st_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- local ports ----------------
   assign ram_en    = (st_q == ST_LOCAL) && (tgt_q == TGT_RAM);
   assign reg_en    = (st_q == ST_LOCAL) && (tgt_q == TGT_REG);
   assign ram_we    = ram_en ? wstrb_q : '0;
   assign reg_we    = reg_en ? wstrb_q : '0;
   assign ram_addr  = RAM_AW'((addr_q - RAM_BASE) >> BYTE_SH);
   assign reg_addr  = REG_AW'((addr_q - REG_BASE) >> BYTE_SH);
   assign ram_wdata = wdata_q;
   assign reg_wdata = wdata_q;

   // ---------------- requester response ----------------
   assign req_ready = (st_q == ST_LOCAL_RSP) || (st_q == ST_BUS_RSP);
   assign bus_fault = fault_q;

   always_comb begin
      unique case (st_q)
         ST_LOCAL_RSP: req_rdata = (tgt_q == TGT_RAM) ? ram_rdata : reg_rdata;
         ST_BUS_RSP:   req_rdata = bus_rdata_q;
         default:      req_rdata = '0;
      endcase
   end

   // R4: at most one target is driven in any cycle
   p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({m0_cyc, m1_cyc, ram_en, reg_en}));

   // R2: local strobe lasts one cycle and is answered in the next
   p_local_turnaround_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en || reg_en) |=> (req_ready && !ram_en && !reg_en));

   // R6: completion is a single-cycle pulse
   p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   // R7: fault flag never falls outside reset
   p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_fault |=> bus_fault);

   // R7: an error on port 0 completes with zero data
   p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m0_cyc && m0_err && !m0_stall) |=> (req_ready && req_rdata == '0 && bus_fault));

endmodule

// File: tb/tb_cpmem_router.sv
`timescale 1ns/1ps
module tb_cpmem_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_fetch = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [3:0]  req_wstrb = '0;
   logic        req_ready;
   logic [31:0] req_rdata;
   logic        bus_fault;
   logic        ram_en, reg_en;
   logic [3:0]  ram_we, reg_we;
   logic [9:0]  ram_addr;
   logic [4:0]  reg_addr;
   logic [31:0] ram_wdata, reg_wdata;
   logic [31:0] ram_rdata = '0, reg_rdata = '0;
   logic        m0_cyc, m0_stb, m0_we, m0_fetch, m1_cyc, m1_stb, m1_we, m1_fetch;
   logic [31:0] m0_adr, m0_dat_w, m1_adr, m1_dat_w;
   logic [3:0]  m0_sel, m1_sel;
   logic [31:0] m0_dat_r = '0, m1_dat_r = '0;
   logic        m0_ack = 0, m0_err = 0, m0_stall = 0;
   logic        m1_ack = 0, m1_err = 0, m1_stall = 0;

   int checks = 0;
   int errors = 0;
   bit exp_fault = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   cpmem_router dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_fetch(req_fetch), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_wstrb(req_wstrb),
      .req_ready(req_ready), .req_rdata(req_rdata), .bus_fault(bus_fault),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .m0_cyc(m0_cyc), .m0_stb(m0_stb), .m0_we(m0_we), .m0_adr(m0_adr),
      .m0_sel(m0_sel), .m0_dat_w(m0_dat_w), .m0_fetch(m0_fetch),
      .m0_dat_r(m0_dat_r), .m0_ack(m0_ack), .m0_err(m0_err), .m0_stall(m0_stall),
      .m1_cyc(m1_cyc), .m1_stb(m1_stb), .m1_we(m1_we), .m1_adr(m1_adr),
      .m1_sel(m1_sel), .m1_dat_w(m1_dat_w), .m1_fetch(m1_fetch),
      .m1_dat_r(m1_dat_r), .m1_ack(m1_ack), .m1_err(m1_err), .m1_stall(m1_stall)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // 0 = RAM, 1 = registers, 2 = port 0, 3 = port 1
   function automatic int exp_target(input logic [31:0] a);
      if (a >= 32'h1000_2000 && a < 32'h1000_3000) return 0;
      if (a >= 32'h1000_3000 && a < 32'h1000_3080) return 1;
      if (a < 32'h5000_0000) return 2;
      return 3;
   endfunction

   function automatic string tgt_req(input int t);
      case (t)
         0: return "R2";
         1: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic access(input logic [31:0] a, input logic [31:0] wd, input logic [3:0] ws,
                         input logic f, input int stall_n, input int wait_n, input bit give_err);
      int t = exp_target(a);
      int mask = 0, en_k = -1, rdy_k = -1, cyc_cnt = 0;
      int stall_left = stall_n, wait_left = wait_n;
      bit done = 0, first = 1, hold_ok = 1, field_ok = 1, fetch_ok = 1, local_ok = 1;
      logic [31:0] adr0 = '0, dw0 = '0, got = '0, exp_rd;
      logic [3:0]  sel0 = '0;
      logic [3:0]  exp_sel = (ws != 0) ? ws : 4'hF;
      @(negedge clk);
      req_valid = 1; req_addr = a; req_wdata = wd; req_wstrb = ws; req_fetch = f;
      ram_rdata = 32'hDEAD_0001; reg_rdata = 32'hDEAD_0002;
      m0_dat_r = 32'hDEAD_0003; m1_dat_r = 32'hDEAD_0004;
      for (int k = 0; k < 40 && !done; k++) begin
         @(negedge clk);
         if (ram_en) begin
            mask |= 1; en_k = k;
            if (ram_addr != 10'((a - 32'h1000_2000) >> 2) || ram_we != ws ||
                (ws != 0 && ram_wdata != wd)) local_ok = 0;
            ram_rdata = 32'hA500_0000 ^ a;
         end
         if (reg_en) begin
            mask |= 2; en_k = k;
            if (reg_addr != 5'((a - 32'h1000_3000) >> 2) || reg_we != ws ||
                (ws != 0 && reg_wdata != wd)) local_ok = 0;
            reg_rdata = 32'h5A00_0000 ^ a;
         end
         if (m0_cyc || m1_cyc) begin
            bit p = m1_cyc;
            logic [31:0] adr_c = p ? m1_adr : m0_adr;
            logic [31:0] dw_c  = p ? m1_dat_w : m0_dat_w;
            logic [3:0]  sel_c = p ? m1_sel : m0_sel;
            mask |= p ? 8 : 4;
            cyc_cnt++;
            if (!(p ? m1_stb : m0_stb)) hold_ok = 0;
            if ((p ? m1_fetch : m0_fetch) != f) fetch_ok = 0;
            if (first) begin
               first = 0; adr0 = adr_c; dw0 = dw_c; sel0 = sel_c;
               if (adr_c != a || sel_c != exp_sel || (p ? m1_we : m0_we) != (ws != 0) ||
                   (ws != 0 && dw_c != wd)) field_ok = 0;
            end else if (adr_c != adr0 || sel_c != sel0 || dw_c != dw0) hold_ok = 0;
            if (stall_left > 0) begin
               stall_left--;
               if (p) m1_stall = 1; else m0_stall = 1;
            end else if (wait_left > 0) begin
               wait_left--;
               m0_stall = 0; m1_stall = 0;
            end else begin
               m0_stall = 0; m1_stall = 0;
               if (p) begin
                  m1_dat_r = 32'h3300_0000 ^ a;
                  if (give_err) m1_err = 1; else m1_ack = 1;
               end else begin
                  m0_dat_r = 32'h1100_0000 ^ a;
                  if (give_err) m0_err = 1; else m0_ack = 1;
               end
            end
         end
         if (req_ready) begin
            rdy_k = k; done = 1; got = req_rdata;
            req_valid = 0; req_wstrb = 0; req_fetch = 0;
            m0_ack = 0; m0_err = 0; m1_ack = 0; m1_err = 0; m0_stall = 0; m1_stall = 0;
         end
      end
      case (t)
         0: exp_rd = 32'hA500_0000 ^ a;
         1: exp_rd = 32'h5A00_0000 ^ a;
         2: exp_rd = give_err ? 32'h0 : (32'h1100_0000 ^ a);
         default: exp_rd = give_err ? 32'h0 : (32'h3300_0000 ^ a);
      endcase
      if (t >= 2 && give_err) exp_fault = 1;
      check(mask == (1 << t), tgt_req(t), $sformatf("target for %h", a), 32'(mask), 32'(1 << t));
      check(got == exp_rd, give_err ? "R7" : "R6", $sformatf("read data for %h", a), got, exp_rd);
      check(bus_fault == exp_fault, "R7", "sticky fault flag", 32'(bus_fault), 32'(exp_fault));
      if (t < 2) begin
         check(en_k == 0 && rdy_k == 1, tgt_req(t), "local strobe/ready timing",
               32'(rdy_k), 32'd1);
         check(local_ok, "R8", $sformatf("local index/enables for %h", a), 32'(ram_we | reg_we), 32'(ws));
      end else begin
         check(rdy_k == stall_n + wait_n + 1 && cyc_cnt == stall_n + wait_n + 1, "R5",
               $sformatf("bus cycle length for %h", a), 32'(cyc_cnt), 32'(stall_n + wait_n + 1));
         check(hold_ok, "R5", "strobe and fields held under stall", 32'(hold_ok), 32'd1);
         check(field_ok, "R8", $sformatf("bus address/select/we for %h", a), {28'd0, sel0}, {28'd0, exp_sel});
         check(fetch_ok, "R9", "fetch tag on bus", 32'(f), 32'(f));
      end
      @(negedge clk);
      check(!req_ready && !ram_en && !reg_en && !m0_cyc && !m1_cyc && req_rdata == 0, "R6",
            "quiet after single ready pulse", 32'(req_ready), 32'd0);
   endtask

   task automatic check_reset_state();
      check(!req_ready && !ram_en && !reg_en && !m0_cyc && !m1_cyc, "R1",
            "outputs idle after reset", {27'd0, req_ready, ram_en, reg_en, m0_cyc, m1_cyc}, 32'd0);
      check(!bus_fault, "R1", "fault flag clear after reset", 32'(bus_fault), 32'd0);
   endtask

   logic [31:0] edges [13] = '{32'h0000_0000, 32'h1000_1FFC, 32'h1000_2000, 32'h1000_2FFC,
                               32'h1000_3000, 32'h1000_307C, 32'h1000_3080, 32'h4FFF_FFFC,
                               32'h5000_0000, 32'h5000_0004, 32'hFFFF_FFFC, 32'h1000_2800,
                               32'h1000_3040};
   logic [3:0]  strobes [4] = '{4'hF, 4'h3, 4'hC, 4'h8};
   logic [27:0] offs [3] = '{28'h000_2004, 28'h000_3010, 28'h000_0100};

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1;
      @(negedge clk);
      check_reset_state();
      // boundary sweep: reads (some as fetches) then writes
      for (int i = 0; i < 13; i++) begin
         access(edges[i], 32'h0, 4'h0, 1'(i % 2), i % 3, (i / 3) % 3, 0);
         access(edges[i], 32'hC0DE_0000 + 32'(i), strobes[i % 4], 1'b0, (i + 1) % 3, i % 2, 0);
      end
      // top-nibble sweep, fetch and data
      for (int n = 0; n < 16; n++) begin
         for (int o = 0; o < 3; o++) begin
            access({4'(n), offs[o]}, 32'h0, 4'h0, 1'(o == 1), n % 2, n % 3, 0);
         end
      end
      // error responses (R7)
      access(32'h2000_0000, 32'h0, 4'h0, 1'b0, 0, 1, 1);
      access(32'h1000_2010, 32'h0, 4'h0, 1'b0, 0, 0, 0);
      access(32'h6000_0040, 32'h1234_5678, 4'hF, 1'b0, 2, 0, 0);
      access(32'h7000_0000, 32'h0, 4'h0, 1'b1, 2, 1, 1);
      access(32'h0000_4000, 32'h0, 4'h0, 1'b0, 1, 0, 0);
      // reset clears the fault flag (R1, R7)
      @(negedge clk); rst_n = 0;
      @(negedge clk); @(negedge clk);
      check_reset_state();
      rst_n = 1; exp_fault = 0;
      access(32'h4000_0000, 32'h0, 4'h0, 1'b0, 0, 0, 0);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule